// File: doc/BRIEF.md
# Dual Hardware Stack Controller

This block keeps two stacks inside one shared 256-byte data RAM on behalf of an 8-bit processor core. The return stack serves subroutine calls, subroutine returns, interrupt entry and interrupt return. It stores a 14-bit program counter together with the carry and zero flags as a two-byte frame, and it owns the interrupt-enable bit. The operand stack serves single-byte push and pop. The two stacks grow toward each other: the return stack counts upward from its pointer, and the operand stack counts downward and wraps to the top of the RAM.

The core issues one operation at a time on `op_valid_i`/`op_i`. The block drives the RAM address, write data and the read and write strobes. It sequences the two-cycle frame saves and restores, and it reports `busy_o` while the second access of a frame is under way. Firmware can load the return-stack pointer from the accumulator, and it can exchange the operand-stack pointer with the accumulator. The RAM array lives outside the block and answers reads combinationally on `ram_rdata_i`.

Top module: `dual_stack_ctrl`

## Requirements
- R1: After reset both stack pointers are 0x00, `int_en_o` is 0, `busy_o` is 0 and neither RAM strobe is active.
- R2: An operation is taken on a cycle with `op_valid_i` high and `busy_o` low. The `op_i` codes are 0 call, 1 interrupt entry, 2 return, 3 return-from-interrupt, 4 push, 5 pop, 6 load return pointer, 7 swap operand pointer.
- R3: Call and interrupt entry write PC[7:0] at the return pointer P in the acceptance cycle. In the next cycle, with `busy_o` high, they write {carry, zero, PC[13:8]} (carry in bit 7, zero in bit 6) at P+1. The pointer ends at P+2.
- R4: Interrupt entry clears `int_en_o` from the cycle after acceptance. Call leaves it unchanged.
- R5: Return reads at P-1 in the acceptance cycle and at P-2 in the next cycle, leaving the pointer at P-2. In the cycle after that, `pc_o` holds the restored counter with a one-cycle `pc_load_o`. `flags_load_o` stays low, and `carry_o` and `zero_o` keep their values.
- R6: Return-from-interrupt behaves as R5. In the same cycle as `pc_load_o`, it also pulses `flags_load_o`, sets `carry_o` and `zero_o` from bits 7 and 6 of the byte read first, and sets `int_en_o`.
- R7: Push first decrements the operand pointer D and then writes `push_data_i` at D-1 in the acceptance cycle. When D is 0x00 the write lands at 0xFF.
- R8: Pop reads at D in the acceptance cycle and then sets D to D+1. `pop_data_o` holds the byte, with a one-cycle `pop_valid_o`, in the next cycle.
- R9: Loading the return pointer sets it to `acc_i`. The next frame save uses that value as its address.
- R10: The swap sets D to `acc_i`. In the next cycle it presents the old D on `acc_o` with a one-cycle `acc_valid_o`.
- R11: Both pointers wrap modulo 256. A frame saved at 0xFF uses 0xFF and then 0x00.
- R12: An operation presented while `busy_o` is high is ignored: it causes no RAM access and no pointer change.
- R13: The write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid_i | input | 1 | Operation request |
| op_i | input | 3 | Operation code |
| pc_i | input | 14 | Program counter to save |
| carry_i | input | 1 | Carry flag to save |
| zero_i | input | 1 | Zero flag to save |
| acc_i | input | 8 | Accumulator value for pointer load or swap |
| push_data_i | input | 8 | Byte to push |
| ram_rdata_i | input | 8 | RAM read data (combinational) |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| busy_o | output | 1 | Second frame access in progress |
| pc_o | output | 14 | Restored program counter |
| pc_load_o | output | 1 | Restored counter valid |
| carry_o | output | 1 | Restored carry |
| zero_o | output | 1 | Restored zero |
| flags_load_o | output | 1 | Restored flags valid |
| int_en_o | output | 1 | Interrupt enable |
| pop_data_o | output | 8 | Popped byte |
| pop_valid_o | output | 1 | Popped byte valid |
| acc_o | output | 8 | Old operand pointer after a swap |
| acc_valid_o | output | 1 | Swap result valid |

## Verification
RAM address, data and strobes for the first access of any operation appear combinationally in the acceptance cycle. The second access of a frame appears in the next cycle. Pop data, swap results and the interrupt-enable clear are due one cycle after acceptance. A restored counter and flags, and the interrupt-enable set after a return-from-interrupt, are due two cycles after acceptance. The bench drives each operation at a falling edge and samples 1 ns after that falling edge and after the next two. Each sample is compared only against the result due in that cycle. The return pointer is swept over all 256 values and the operand pointer over all 256 values, and both are observed through the RAM addresses they produce.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

  typedef enum logic [2:0] {
    OP_CALL    = 3'd0,
    OP_IRQ     = 3'd1,
    OP_RET     = 3'd2,
    OP_RETI    = 3'd3,
    OP_PUSH    = 3'd4,
    OP_POP     = 3'd5,
    OP_LDPSP   = 3'd6,
    OP_SWAPDSP = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_SAVE2 = 2'd1,
    PS_REST2 = 2'd2
  } ps_state_e;

endpackage

// File: rtl/ret_stack_seq.sv
module ret_stack_seq
  import dstk_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PCW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_save,
  input  logic           start_rest,
  input  logic           is_irq,
  input  logic           is_reti,
  input  logic           ld_ptr,
  input  logic [DW-1:0]  ld_val,
  input  logic [PCW-1:0] pc_i,
  input  logic           carry_i,
  input  logic           zero_i,
  input  logic [DW-1:0]  rdata,
  output logic           busy,
  output logic           access,
  output logic [DW-1:0]  addr,
  output logic           we,
  output logic           re,
  output logic [DW-1:0]  wdata,
  output logic [PCW-1:0] pc_o,
  output logic           pc_load,
  output logic           carry_o,
  output logic           zero_o,
  output logic           flags_load,
  output logic           int_en
);

  localparam int HIW = PCW - DW;

  function automatic logic [DW-1:0] frame_lo(input logic [PCW-1:0] pc);
    return pc[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] frame_hi(input logic [PCW-1:0] pc,
                                             input logic c, input logic z);
    return {c, z, pc[PCW-1:DW]};
  endfunction

  function automatic logic [DW-1:0] ptr_up(input logic [DW-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [DW-1:0] ptr_dn(input logic [DW-1:0] p);
    return p - 1'b1;
  endfunction

  ps_state_e       state;
  logic [DW-1:0]   psp;
  logic [DW-1:0]   held;
  logic            rest_reti;

  always_comb begin
    addr  = psp;
    we    = 1'b0;
    re    = 1'b0;
    wdata = '0;
    unique case (state)
      PS_IDLE: begin
        if (start_save) begin
          we    = 1'b1;
          wdata = frame_lo(pc_i);
        end else if (start_rest) begin
          addr = ptr_dn(psp);
          re   = 1'b1;
        end
      end
      PS_SAVE2: begin
        we    = 1'b1;
        wdata = held;
      end
      PS_REST2: begin
        addr = ptr_dn(psp);
        re   = 1'b1;
      end
      default: ;
    endcase
  end

  assign access = we | re;
  assign busy   = (state != PS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_IDLE;
      psp        <= '0;
      held       <= '0;
      rest_reti  <= 1'b0;
      pc_o       <= '0;
      pc_load    <= 1'b0;
      carry_o    <= 1'b0;
      zero_o     <= 1'b0;
      flags_load <= 1'b0;
      int_en     <= 1'b0;
    end else begin
      pc_load    <= 1'b0;
      flags_load <= 1'b0;
      unique case (state)
        PS_IDLE: begin
          if (start_save) begin
            held  <= frame_hi(pc_i, carry_i, zero_i);
            psp   <= ptr_up(psp);
            state <= PS_SAVE2;
            if (is_irq) int_en <= 1'b0;
          end else if (start_rest) begin
            held      <= rdata;
            psp       <= ptr_dn(psp);
            rest_reti <= is_reti;
            state     <= PS_REST2;
          end else if (ld_ptr) begin
            psp <= ld_val;
          end
        end
        PS_SAVE2: begin
          psp   <= ptr_up(psp);
          state <= PS_IDLE;
        end
        PS_REST2: begin
          psp     <= ptr_dn(psp);
          pc_o    <= {held[HIW-1:0], rdata};
          pc_load <= 1'b1;
          if (rest_reti) begin
            carry_o    <= held[DW-1];
            zero_o     <= held[DW-2];
            flags_load <= 1'b1;
            int_en     <= 1'b1;
          end
          state <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  // R3: a save moves the pointer by two over the two cycles
  a_r3_save_plus_two: assert property (@(posedge clk) disable iff (!rst_n)
    start_save |=> ##1 (psp == $past(psp, 2) + 2'd2));
  // R3: the second write follows in the busy cycle
  a_r3_second_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_save |=> (we && busy));
  // R4: interrupt entry drops the enable
  a_r4_irq_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (start_save && is_irq) |=> !int_en);
  // R5: plain return leaves the flags alone
  a_r5_ret_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_REST2 && !rest_reti) |=> (!flags_load && $stable(carry_o) && $stable(zero_o)));
  // R6: return-from-interrupt re-enables together with the flags
  a_r6_reti_sets_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_REST2 && rest_reti) |=> (int_en && flags_load && pc_load));
  // R12: busy lasts exactly one cycle
  a_r12_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

endmodule

// File: rtl/opnd_stack_unit.sv
module opnd_stack_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          swap,
  input  logic [DW-1:0] swap_val,
  input  logic [DW-1:0] push_data,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] addr,
  output logic          we,
  output logic          re,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  output logic [DW-1:0] acc_o,
  output logic          acc_valid
);

  function automatic logic [DW-1:0] pre_dec(input logic [DW-1:0] p);
    return p - 1'b1;
  endfunction

  function automatic logic [DW-1:0] post_inc(input logic [DW-1:0] p);
    return p + 1'b1;
  endfunction

  logic [DW-1:0] dsp;

  assign addr  = push ? pre_dec(dsp) : dsp;
  assign we    = push;
  assign re    = pop;
  assign wdata = push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsp       <= '0;
      pop_data  <= '0;
      pop_valid <= 1'b0;
      acc_o     <= '0;
      acc_valid <= 1'b0;
    end else begin
      pop_valid <= 1'b0;
      acc_valid <= 1'b0;
      if (push) begin
        dsp <= pre_dec(dsp);
      end else if (pop) begin
        dsp       <= post_inc(dsp);
        pop_data  <= rdata;
        pop_valid <= 1'b1;
      end else if (swap) begin
        dsp       <= swap_val;
        acc_o     <= dsp;
        acc_valid <= 1'b1;
      end
    end
  end

  // R7: push moves the pointer down by one
  a_r7_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (dsp == $past(dsp) - 1'b1));
  // R8: pop moves the pointer up and flags the data
  a_r8_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (pop_valid && dsp == $past(dsp) + 1'b1));
  // R10: swap presents the old pointer
  a_r10_swap_old: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (acc_valid && acc_o == $past(dsp)));

endmodule

// File: rtl/stk_ram_port.sv
module stk_ram_port #(
  parameter int DW = 8
) (
  input  logic          ps_access,
  input  logic [DW-1:0] ps_addr,
  input  logic          ps_we,
  input  logic          ps_re,
  input  logic [DW-1:0] ps_wdata,
  input  logic [DW-1:0] ds_addr,
  input  logic          ds_we,
  input  logic          ds_re,
  input  logic [DW-1:0] ds_wdata,
  output logic [DW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata
);

  always_comb begin
    if (ps_access) begin
      ram_addr  = ps_addr;
      ram_we    = ps_we;
      ram_re    = ps_re;
      ram_wdata = ps_wdata;
    end else begin
      ram_addr  = ds_addr;
      ram_we    = ds_we;
      ram_re    = ds_re;
      ram_wdata = ds_wdata;
    end
  end

endmodule

// File: rtl/dual_stack_ctrl.sv
module dual_stack_ctrl
  import dstk_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PCW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid_i,
  input  logic [2:0]     op_i,
  input  logic [PCW-1:0] pc_i,
  input  logic           carry_i,
  input  logic           zero_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic [DW-1:0]  ram_rdata_i,
  output logic [DW-1:0]  ram_addr_o,
  output logic [DW-1:0]  ram_wdata_o,
  output logic           ram_we_o,
  output logic           ram_re_o,
  output logic           busy_o,
  output logic [PCW-1:0] pc_o,
  output logic           pc_load_o,
  output logic           carry_o,
  output logic           zero_o,
  output logic           flags_load_o,
  output logic           int_en_o,
  output logic [DW-1:0]  pop_data_o,
  output logic           pop_valid_o,
  output logic [DW-1:0]  acc_o,
  output logic           acc_valid_o
);

  stk_op_e op_e;
  logic    accept;
  logic    ev_save, ev_rest, ev_irq, ev_reti, ev_ldpsp;
  logic    ev_push, ev_pop, ev_swap;

  assign op_e   = stk_op_e'(op_i);
  assign accept = op_valid_i & ~busy_o;

  always_comb begin
    ev_save  = 1'b0;
    ev_rest  = 1'b0;
    ev_irq   = 1'b0;
    ev_reti  = 1'b0;
    ev_ldpsp = 1'b0;
    ev_push  = 1'b0;
    ev_pop   = 1'b0;
    ev_swap  = 1'b0;
    if (accept) begin
      unique case (op_e)
        OP_CALL:    ev_save  = 1'b1;
        OP_IRQ:     begin ev_save = 1'b1; ev_irq = 1'b1; end
        OP_RET:     ev_rest  = 1'b1;
        OP_RETI:    begin ev_rest = 1'b1; ev_reti = 1'b1; end
        OP_PUSH:    ev_push  = 1'b1;
        OP_POP:     ev_pop   = 1'b1;
        OP_LDPSP:   ev_ldpsp = 1'b1;
        OP_SWAPDSP: ev_swap  = 1'b1;
        default: ;
      endcase
    end
  end

  logic          ps_access, ps_we, ps_re;
  logic [DW-1:0] ps_addr, ps_wdata;
  logic          ds_we, ds_re;
  logic [DW-1:0] ds_addr, ds_wdata;

  ret_stack_seq #(.DW(DW), .PCW(PCW)) u_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_save (ev_save),
    .start_rest (ev_rest),
    .is_irq     (ev_irq),
    .is_reti    (ev_reti),
    .ld_ptr     (ev_ldpsp),
    .ld_val     (acc_i),
    .pc_i       (pc_i),
    .carry_i    (carry_i),
    .zero_i     (zero_i),
    .rdata      (ram_rdata_i),
    .busy       (busy_o),
    .access     (ps_access),
    .addr       (ps_addr),
    .we         (ps_we),
    .re         (ps_re),
    .wdata      (ps_wdata),
    .pc_o       (pc_o),
    .pc_load    (pc_load_o),
    .carry_o    (carry_o),
    .zero_o     (zero_o),
    .flags_load (flags_load_o),
    .int_en     (int_en_o)
  );

  opnd_stack_unit #(.DW(DW)) u_opnd (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .pop       (ev_pop),
    .swap      (ev_swap),
    .swap_val  (acc_i),
    .push_data (push_data_i),
    .rdata     (ram_rdata_i),
    .addr      (ds_addr),
    .we        (ds_we),
    .re        (ds_re),
    .wdata     (ds_wdata),
    .pop_data  (pop_data_o),
    .pop_valid (pop_valid_o),
    .acc_o     (acc_o),
    .acc_valid (acc_valid_o)
  );

  stk_ram_port #(.DW(DW)) u_port (
    .ps_access (ps_access),
    .ps_addr   (ps_addr),
    .ps_we     (ps_we),
    .ps_re     (ps_re),
    .ps_wdata  (ps_wdata),
    .ds_addr   (ds_addr),
    .ds_we     (ds_we),
    .ds_re     (ds_re),
    .ds_wdata  (ds_wdata),
    .ram_addr  (ram_addr_o),
    .ram_we    (ram_we_o),
    .ram_re    (ram_re_o),
    .ram_wdata (ram_wdata_o)
  );

  // R13: one RAM direction per cycle
  a_r13_no_we_re: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we_o && ram_re_o));
  // R12: nothing reaches the operand stack while busy
  a_r12_busy_blocks_ds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!ds_we && !ds_re));
  // R2: only one stack touches the RAM in a cycle
  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ps_we | ps_re, ds_we | ds_re}) <= 1);

endmodule

// File: tb/dual_stack_ctrl_tb.sv
module dual_stack_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [13:0] pc = '0;
  logic        cin = 1'b0, zin = 1'b0;
  logic [7:0]  acc = '0, pdata = '0;
  logic [7:0]  rdata, addr, wdata, pop_data, acc_out;
  logic        we, re, busy, pc_load, cout, zout, flags_load, int_en, pop_valid, acc_valid;
  logic [13:0] pc_out;

  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  dual_stack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_i(op), .pc_i(pc),
    .carry_i(cin), .zero_i(zin), .acc_i(acc), .push_data_i(pdata),
    .ram_rdata_i(rdata), .ram_addr_o(addr), .ram_wdata_o(wdata),
    .ram_we_o(we), .ram_re_o(re), .busy_o(busy), .pc_o(pc_out),
    .pc_load_o(pc_load), .carry_o(cout), .zero_o(zout),
    .flags_load_o(flags_load), .int_en_o(int_en), .pop_data_o(pop_data),
    .pop_valid_o(pop_valid), .acc_o(acc_out), .acc_valid_o(acc_valid)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  int tests = 0;
  int fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // captured samples for the three cycles of one operation
  logic [7:0]  c0_addr, c0_wd, c1_addr, c1_wd, c1_pop, c1_acc;
  logic        c0_we, c0_re, c1_we, c1_re, c1_busy, c1_popv, c1_accv, c1_ie;
  logic        c2_pcl, c2_fl, c2_c, c2_z, c2_ie;
  logic [13:0] c2_pc;

  task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic [13:0] p,
                        input logic c, input logic z, input logic [7:0] d,
                        input bit hold, input logic [2:0] hold_op);
    @(negedge clk);
    op_valid = 1'b1; op = o; acc = a; pc = p; cin = c; zin = z; pdata = d;
    #1;
    c0_addr = addr; c0_wd = wdata; c0_we = we; c0_re = re;
    chk("R13 cycle0", {31'd0, we & re}, 32'd0);
    @(negedge clk);
    if (hold) begin op = hold_op; acc = 8'hEE; pdata = 8'h77; end
    else op_valid = 1'b0;
    #1;
    c1_addr = addr; c1_wd = wdata; c1_we = we; c1_re = re; c1_busy = busy;
    c1_pop = pop_data; c1_popv = pop_valid; c1_acc = acc_out; c1_accv = acc_valid;
    c1_ie = int_en;
    chk("R13 cycle1", {31'd0, we & re}, 32'd0);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    c2_pcl = pc_load; c2_pc = pc_out; c2_fl = flags_load; c2_c = cout; c2_z = zout;
    c2_ie = int_en;
  endtask

  function automatic logic [7:0] hi_of(input logic [13:0] p, input logic c, input logic z);
    return {c, z, p[13:8]};
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] exp_dsp;
    logic [7:0] saved_c;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 int_en", {31'd0, int_en}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 strobes", {30'd0, we, re}, 32'd0);
    rst_n = 1'b1;

    // R1 R7: first push from reset pointer 0 lands at 0xFF
    run_op(3'd4, 8'h00, 14'h0, 1'b0, 1'b0, 8'h5A, 1'b0, 3'd0);
    chk("R7 push wrap addr", {24'd0, c0_addr}, 32'hFF);
    chk("R7 push we", {31'd0, c0_we}, 32'd1);
    chk("R7 push data", {24'd0, c0_wd}, 32'h5A);
    // R8: pop it back
    run_op(3'd5, 8'h00, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R8 pop addr", {24'd0, c0_addr}, 32'hFF);
    chk("R8 pop re", {31'd0, c0_re}, 32'd1);
    chk("R8 pop valid", {31'd0, c1_popv}, 32'd1);
    chk("R8 pop data", {24'd0, c1_pop}, 32'h5A);
    // R1: return pointer starts at 0
    run_op(3'd0, 8'h00, 14'h2ABC, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R1 call addr", {24'd0, c0_addr}, 32'h00);
    chk("R3 second addr", {24'd0, c1_addr}, 32'h01);
    run_op(3'd2, 8'h00, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R5 ret pc", {18'd0, c2_pc}, 32'h2ABC);

    // R3 R5 R9 R11: sweep every return pointer value
    for (int p = 0; p < 256; p++) begin
      logic [7:0]  pb;
      logic [13:0] pv;
      logic        cc, zz;
      pb = p[7:0];
      pv = 14'((p * 61 + 7) ^ (p << 6));
      cc = p[0]; zz = p[1];
      run_op(3'd6, pb, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
      run_op(3'd0, 8'h00, pv, cc, zz, 8'h00, 1'b0, 3'd0);
      chk("R9 R3 lo addr", {24'd0, c0_addr}, {24'd0, pb});
      chk("R3 lo data", {22'd0, c0_we, c0_wd}, {23'd0, 1'b1, pv[7:0]});
      chk("R11 R3 hi addr", {24'd0, c1_addr}, {24'd0, 8'(pb + 8'd1)});
      chk("R3 hi data", {22'd0, c1_we, c1_wd}, {23'd0, 1'b1, hi_of(pv, cc, zz)});
      chk("R3 busy", {31'd0, c1_busy}, 32'd1);
      run_op(3'd2, 8'h00, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
      chk("R5 first read", {23'd0, c0_re, c0_addr}, {23'd0, 1'b1, 8'(pb + 8'd1)});
      chk("R5 second read", {23'd0, c1_re, c1_addr}, {23'd0, 1'b1, pb});
      chk("R5 pc", {17'd0, c2_pcl, c2_pc}, {17'd0, 1'b1, pv});
      chk("R5 no flags", {31'd0, c2_fl}, 32'd0);
    end

    // R4 R6: interrupt entry and return-from-interrupt
    run_op(3'd6, 8'h40, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    run_op(3'd1, 8'h00, 14'h1234, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R4 irq ie", {31'd0, c1_ie}, 32'd0);
    run_op(3'd3, 8'h00, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R6 pc", {17'd0, c2_pcl, c2_pc}, {17'd0, 1'b1, 14'h1234});
    chk("R6 flags", {29'd0, c2_fl, c2_c, c2_z}, {29'd0, 3'b110});
    chk("R6 ie", {31'd0, c2_ie}, 32'd1);
    run_op(3'd0, 8'h00, 14'h0777, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0);
    chk("R4 call keeps ie", {31'd0, c1_ie}, 32'd1);
    run_op(3'd2, 8'h00, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R5 flags kept", {29'd0, c2_fl, c2_c, c2_z}, {29'd0, 3'b010});
    chk("R5 ie kept", {31'd0, c2_ie}, 32'd1);
    run_op(3'd1, 8'h00, 14'h0001, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R4 irq clears", {31'd0, c1_ie}, 32'd0);

    // R7 R8 R10 R11: sweep every operand pointer value
    exp_dsp = 8'h00;
    for (int d = 0; d < 256; d++) begin
      logic [7:0] db, vb;
      db = d[7:0];
      vb = db ^ 8'hA5;
      run_op(3'd7, db, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
      chk("R10 swap old", {23'd0, c1_accv, c1_acc}, {23'd0, 1'b1, exp_dsp});
      run_op(3'd4, 8'h00, 14'h0, 1'b0, 1'b0, vb, 1'b0, 3'd0);
      chk("R7 R11 push addr", {23'd0, c0_we, c0_addr}, {23'd0, 1'b1, 8'(db - 8'd1)});
      chk("R7 push data", {24'd0, c0_wd}, {24'd0, vb});
      run_op(3'd5, 8'h00, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
      chk("R8 pop addr", {23'd0, c0_re, c0_addr}, {23'd0, 1'b1, 8'(db - 8'd1)});
      chk("R8 pop data", {23'd0, c1_popv, c1_pop}, {23'd0, 1'b1, vb});
      exp_dsp = db;
    end

    // R12: push presented while busy is ignored
    run_op(3'd7, 8'h80, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    saved_c = mem[8'h7F];
    run_op(3'd6, 8'h10, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    run_op(3'd0, 8'h00, 14'h3F00, 1'b1, 1'b1, 8'h00, 1'b1, 3'd4);
    chk("R12 busy addr", {23'd0, c1_we, c1_addr}, {23'd0, 1'b1, 8'h11});
    chk("R12 busy data", {24'd0, c1_wd}, {24'd0, hi_of(14'h3F00, 1'b1, 1'b1)});
    chk("R12 ram untouched", {24'd0, mem[8'h7F]}, {24'd0, saved_c});
    run_op(3'd7, 8'h00, 14'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R12 dsp unchanged", {24'd0, c1_acc}, 32'h80);
    // R2: load pointer result observed through next call
    run_op(3'd0, 8'h00, 14'h0005, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R2 psp after ignored op", {24'd0, c0_addr}, 32'h12);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule